// File: doc/BRIEF.md
# Partial Register Write Merger

This block holds a small file of 64-bit integer registers that accept writes narrower than the register. Each write names a register, a width view and data. Five views exist: full 64-bit, 32-bit, 16-bit, low byte and high byte. Only the first four registers have a high-byte view. A 32-bit write zero-extends into the upper half. A 16-bit or low-byte write leaves every bit outside its field as it was.

A high-byte write is not folded into the register at once. The byte is kept in a side slot and the register is marked split. A later 16-, 32- or 64-bit read of a split register must first merge the side byte into bits 15:8. The read port drops ready for one cycle while that merge takes place. With the request held, the merged value is served on the next cycle. Byte-wide reads are served at once from whichever copy is current.

The read port is combinational from the register state, so a read returns the value from before any write in the same cycle. It fits a scheduler model or a pipeline model where the cost of partial writes must be visible cycle by cycle.

Top module: `prw_merger`

## Requirements
- R1: After the active-low asynchronous reset, every register reads as zero, no register is split, and a read is accepted with rd_ready_o high.
- R2: Width code 0 (64-bit) replaces all 64 bits. Width code 1 (32-bit) writes bits 31:0 and clears bits 63:32.
- R3: Width code 2 (16-bit) writes bits 15:0, and width code 3 (low byte) writes bits 7:0. Both leave all other bits unchanged.
- R4: Width code 4 (high byte) to register index 0..3 takes wr_data_i[7:0] and changes only bits 15:8. To any index of 4 or more it is ignored. A high-byte read of such an index returns zero without a stall.
- R5: Read data is the selected view, right-aligned and zero-extended to 64 bits, with width codes as in R2 to R4.
- R6: A 64-, 32- or 16-bit read of a split register holds rd_ready_o low for exactly one cycle. If the request is held, the next cycle delivers the merged value with rd_ready_o high.
- R7: Low-byte and high-byte reads never stall. A high-byte read returns the most recently written high byte.
- R8: A high-byte write sets the split flag. A merge, or a 64-, 32- or 16-bit write, clears it. A low-byte write leaves it set.
- R9: A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request |
| wr_idx_i | input | 4 | Write register index |
| wr_width_i | input | 3 | Write view: 0=64, 1=32, 2=16, 3=low byte, 4=high byte |
| wr_data_i | input | 64 | Write data, right-aligned |
| rd_valid_i | input | 1 | Read request |
| rd_idx_i | input | 4 | Read register index |
| rd_width_i | input | 3 | Read view, same codes as writes |
| rd_ready_o | output | 1 | Read served this cycle; low during a merge |
| rd_data_o | output | 64 | Read data, valid when rd_valid_i and rd_ready_o |

## Verification
On every cycle the assertions check the following. Byte-wide reads never stall. A stalled read that is held, with no new high-byte write to its register, is served on the next cycle. A 32-bit write leaves the upper half zero. The split flag follows high-byte and wide writes. A high-byte write to a register without that view leaves the file untouched. The data values are checked only by the bench's scenarios. These include how each width preserves neighbouring bits, the merged value after a stall, the pre-write value on a same-cycle read, and the effect of a low-byte write on a split register.

// File: rtl/prw_pkg.sv
`timescale 1ns/1ps
package prw_pkg;
  typedef enum logic [2:0] {
    WID_64 = 3'd0,
    WID_32 = 3'd1,
    WID_16 = 3'd2,
    WID_L8 = 3'd3,
    WID_H8 = 3'd4
  } width_e;

  function automatic logic is_wide(width_e w);
    return (w == WID_64) || (w == WID_32) || (w == WID_16);
  endfunction
endpackage

// File: rtl/prw_reg_slot.sv
`timescale 1ns/1ps
module prw_reg_slot
  import prw_pkg::*;
#(
  parameter int  DATA_W = 64,
  parameter bit  HAS_HB = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  width_e            wr_width_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              merge_i,
  output logic [DATA_W-1:0] val_o,
  output logic [7:0]        hb_o,
  output logic              split_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] val_q, val_d, base;
  logic [7:0]        hb_q, hb_d;
  logic              split_q, split_d;

  always_comb begin
    base = val_q;
    if (merge_i) base[15:8] = hb_q;
    val_d   = base;
    hb_d    = hb_q;
    split_d = split_q && !merge_i;
    if (wr_hit_i) begin
      case (wr_width_i)
        WID_64: begin
          val_d   = wr_data_i;
          split_d = 1'b0;
        end
        WID_32: begin
          val_d           = '0;
          val_d[HALF_W-1:0] = wr_data_i[HALF_W-1:0];
          split_d         = 1'b0;
        end
        WID_16: begin
          val_d[15:0] = wr_data_i[15:0];
          split_d     = 1'b0;
        end
        WID_L8: val_d[7:0] = wr_data_i[7:0];
        WID_H8: begin
          // byte parked in side slot until a wide read forces the merge
          if (HAS_HB) begin
            hb_d    = wr_data_i[7:0];
            split_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '0;
      hb_q    <= '0;
      split_q <= 1'b0;
    end else begin
      val_q   <= val_d;
      hb_q    <= hb_d;
      split_q <= split_d;
    end
  end

  assign val_o   = val_q;
  assign hb_o    = hb_q;
  assign split_o = split_q;
endmodule

// File: rtl/prw_stall_ctrl.sv
`timescale 1ns/1ps
module prw_stall_ctrl
  import prw_pkg::*;
(
  input  logic   rd_valid_i,
  input  width_e rd_width_i,
  input  logic   split_i,
  output logic   merge_o,
  output logic   ready_o
);
  // one merge cycle per wide read of a split register
  assign merge_o = rd_valid_i && is_wide(rd_width_i) && split_i;
  assign ready_o = !merge_o;
endmodule

// File: rtl/prw_read_view.sv
`timescale 1ns/1ps
module prw_read_view
  import prw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [7:0]        hb_i,
  input  logic              split_i,
  input  logic              has_hb_i,
  input  width_e            width_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    data_o = '0;
    case (width_i)
      WID_64: data_o = val_i;
      WID_32: data_o[HALF_W-1:0] = val_i[HALF_W-1:0];
      WID_16: data_o[15:0] = val_i[15:0];
      WID_L8: data_o[7:0] = val_i[7:0];
      WID_H8: if (has_hb_i) data_o[7:0] = split_i ? hb_i : val_i[15:8];
      default: ;
    endcase
  end
endmodule

// File: rtl/prw_merger.sv
`timescale 1ns/1ps
module prw_merger
  import prw_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  parameter int NUM_HB   = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [2:0]        wr_width_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_valid_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [2:0]        rd_width_i,
  output logic              rd_ready_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
  logic [NUM_REGS-1:0][7:0]        hb_q;
  logic [NUM_REGS-1:0]             split_q;
  width_e wr_w, rd_w;
  logic   merge;

  assign wr_w = width_e'(wr_width_i);
  assign rd_w = width_e'(rd_width_i);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    prw_reg_slot #(
      .DATA_W(DATA_W),
      .HAS_HB(i < NUM_HB)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_hit_i   (wr_valid_i && (wr_idx_i == IDX_W'(i))),
      .wr_width_i (wr_w),
      .wr_data_i  (wr_data_i),
      .merge_i    (merge && (rd_idx_i == IDX_W'(i))),
      .val_o      (reg_q[i]),
      .hb_o       (hb_q[i]),
      .split_o    (split_q[i])
    );
  end

  prw_stall_ctrl u_stall (
    .rd_valid_i (rd_valid_i),
    .rd_width_i (rd_w),
    .split_i    (split_q[rd_idx_i]),
    .merge_o    (merge),
    .ready_o    (rd_ready_o)
  );

  prw_read_view #(.DATA_W(DATA_W)) u_view (
    .val_i    (reg_q[rd_idx_i]),
    .hb_i     (hb_q[rd_idx_i]),
    .split_i  (split_q[rd_idx_i]),
    .has_hb_i (int'(rd_idx_i) < NUM_HB),
    .width_i  (rd_w),
    .data_o   (rd_data_o)
  );
endmodule

// File: rtl/prw_merger_chk.sv
`timescale 1ns/1ps
module prw_merger_chk
  import prw_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  parameter int NUM_HB   = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_valid_i,
  input logic [IDX_W-1:0]                wr_idx_i,
  input logic [2:0]                      wr_width_i,
  input logic                            rd_valid_i,
  input logic [IDX_W-1:0]                rd_idx_i,
  input logic [2:0]                      rd_width_i,
  input logic                            rd_ready_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0] reg_q,
  input logic [NUM_REGS-1:0]             split_q
);
  localparam int HALF_W = DATA_W / 2;

  p_narrow_no_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && (rd_width_i == 3'(WID_L8) || rd_width_i == 3'(WID_H8)) |-> rd_ready_o);

  p_one_cycle_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && !rd_ready_o |=>
      !(rd_valid_i && $stable(rd_idx_i) && $stable(rd_width_i) &&
        !($past(wr_valid_i) && $past(wr_width_i) == 3'(WID_H8) && $past(wr_idx_i) == rd_idx_i))
      || rd_ready_o);

  p_zero_ext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_width_i == 3'(WID_32) |=> reg_q[$past(wr_idx_i)][DATA_W-1:HALF_W] == '0);

  p_hb_sets_split_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_width_i == 3'(WID_H8) && int'(wr_idx_i) < NUM_HB |=> split_q[$past(wr_idx_i)]);

  p_wide_clears_split_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && (wr_width_i == 3'(WID_64) || wr_width_i == 3'(WID_32) || wr_width_i == 3'(WID_16))
      |=> !split_q[$past(wr_idx_i)]);

  p_no_hb_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_width_i == 3'(WID_H8) && int'(wr_idx_i) >= NUM_HB && rd_ready_o
      |=> $stable(reg_q) && $stable(split_q));
endmodule

bind prw_merger prw_merger_chk #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .NUM_HB  (NUM_HB)
) u_chk (.*);

// File: tb/prw_merger_test.sv
`timescale 1ns/1ps
module prw_merger_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [2:0]  wr_width_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        rd_valid_i = 1'b0;
  logic [3:0]  rd_idx_i = '0;
  logic [2:0]  rd_width_i = '0;
  logic        rd_ready_o;
  logic [63:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [2:0] W64 = 3'd0, W32 = 3'd1, W16 = 3'd2, WL8 = 3'd3, WH8 = 3'd4;

  always #2 clk_i = ~clk_i;

  prw_merger uut (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [2:0] w, logic [63:0] d);
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_idx_i = idx; wr_width_i = w; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic rd(string tag, logic [3:0] idx, logic [2:0] w, logic [63:0] exp, bit stall);
    @(negedge clk_i);
    rd_valid_i = 1'b1; rd_idx_i = idx; rd_width_i = w;
    #1;
    if (stall) begin
      check({tag, " ready low"}, 64'(rd_ready_o), 64'd0);
      @(negedge clk_i);
      #1;
    end
    check({tag, " ready"}, 64'(rd_ready_o), 64'd1);
    check({tag, " data"}, rd_data_o, exp);
    rd_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    rd_valid_i = 1'b1; rd_idx_i = 4'd0; rd_width_i = W64;
    #1;
    check("R1 reset data", rd_data_o, 64'd0);
    check("R1 reset ready", 64'(rd_ready_o), 64'd1);
    rd_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd("R1 post-reset r7", 4'd7, W64, 64'd0, 1'b0);
  endtask

  task automatic t_full_widths;
    wr(4'd1, W64, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R2 w64", 4'd1, W64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    wr(4'd1, W32, 64'hDEAD_0000_1234_5678);
    rd("R2 w32 zero-ext", 4'd1, W64, 64'h0000_0000_1234_5678, 1'b0);
    rd("R5 w32 view", 4'd1, W32, 64'h0000_0000_1234_5678, 1'b0);
  endtask

  task automatic t_partial;
    wr(4'd2, W64, 64'h1122_3344_5566_7788);
    wr(4'd2, W16, 64'hFFFF_FFFF_FFFF_AAAA);
    rd("R3 w16 keep", 4'd2, W64, 64'h1122_3344_5566_AAAA, 1'b0);
    wr(4'd2, WL8, 64'hFFFF_FFFF_FFFF_FF55);
    rd("R3 l8 keep", 4'd2, W64, 64'h1122_3344_5566_AA55, 1'b0);
    rd("R5 w16 view", 4'd2, W16, 64'h0000_0000_0000_AA55, 1'b0);
  endtask

  task automatic t_high_byte;
    wr(4'd0, W64, 64'h0102_0304_0506_0708);
    wr(4'd0, WH8, 64'hFFFF_FFFF_FFFF_FFEE);
    rd("R7 h8 read", 4'd0, WH8, 64'h0000_0000_0000_00EE, 1'b0);
    rd("R7 l8 read", 4'd0, WL8, 64'h0000_0000_0000_0008, 1'b0);
    rd("R6 R4 merged w64", 4'd0, W64, 64'h0102_0304_0506_EE08, 1'b1);
    rd("R8 merge clears", 4'd0, W64, 64'h0102_0304_0506_EE08, 1'b0);
  endtask

  task automatic t_wide_clears;
    wr(4'd3, W64, 64'h5555_5555_5555_5555);
    wr(4'd3, WH8, 64'h0000_0000_0000_0011);
    wr(4'd3, W32, 64'h0000_0000_CAFE_BABE);
    rd("R8 w32 clears", 4'd3, W64, 64'h0000_0000_CAFE_BABE, 1'b0);
    wr(4'd1, WH8, 64'h0000_0000_0000_0022);
    wr(4'd1, W16, 64'h0000_0000_0000_BEEF);
    rd("R8 w16 clears", 4'd1, W64, 64'h0000_0000_1234_BEEF, 1'b0);
  endtask

  task automatic t_low_keeps;
    wr(4'd2, WH8, 64'h0000_0000_0000_0033);
    wr(4'd2, WL8, 64'h0000_0000_0000_0044);
    rd("R8 l8 keeps split", 4'd2, W32, 64'h0000_0000_5566_3344, 1'b1);
    rd("R6 w16 after merge", 4'd2, W16, 64'h0000_0000_0000_3344, 1'b0);
  endtask

  task automatic t_no_hb_view;
    wr(4'd5, W64, 64'h0123_4567_89AB_CDEF);
    wr(4'd5, WH8, 64'h0000_0000_0000_0099);
    rd("R4 h8 ignored", 4'd5, W64, 64'h0123_4567_89AB_CDEF, 1'b0);
    rd("R4 h8 read zero", 4'd5, WH8, 64'd0, 1'b0);
  endtask

  task automatic t_same_cycle;
    wr(4'd4, W64, 64'h0000_0000_0000_0A0A);
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_idx_i = 4'd4; wr_width_i = W64; wr_data_i = 64'h0000_0000_0000_B0B0;
    rd_valid_i = 1'b1; rd_idx_i = 4'd4; rd_width_i = W64;
    #1;
    check("R9 old value", rd_data_o, 64'h0000_0000_0000_0A0A);
    @(negedge clk_i);
    wr_valid_i = 1'b0; rd_valid_i = 1'b0;
    rd("R9 new value", 4'd4, W64, 64'h0000_0000_0000_B0B0, 1'b0);
  endtask

  initial begin
    #800_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_full_widths();
    t_partial();
    t_high_byte();
    t_wide_clears();
    t_low_keeps();
    t_no_hb_view();
    t_same_cycle();
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule